// File: doc/BRIEF.md
# Three-Phase Gate Command Conditioner

This block sits between a motor-control PWM source and three half-bridge gate drivers. Each phase has a high-side and a low-side command. Both commands are active-low. The block turns the six raw commands into six gate-enable outputs that are clean and free of shoot-through. First, every command passes through a minimum-width filter, so that short noise pulses never reach a gate. Second, every turn-on is held back until the complementary switch of the same phase has been off for a programmable number of clock cycles.

Two inputs shut the outputs down:

- A shutdown input passes through the same minimum-width filter as the commands. Once the filtered shutdown is active, it switches every gate off.
- A kill input comes from a separate protection block. It takes the outputs low within the current clock cycle, without passing through the filter or the deadtime logic.

All timing is counted in cycles of one system clock. The default filter and deadtime counts are derived from the clock period and the target times in nanoseconds.

Top module: `tph_gate_cond`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every gate output is 0. The deadtime counters start as expired, so the first turn-on after reset waits only for the filter.
- R2: A command bit equal to 0 requests its gate on. A command bit equal to 1 requests it off.
- R3: A command level reaches the gate logic only after it has been sampled on FILT_CYC consecutive rising edges. A pulse shorter than FILT_CYC samples leaves the outputs unchanged.
- R4: From the first rising edge that samples a new command level, a gate output changes FILT_CYC+1 rising edges later when no deadtime wait applies. The pipeline is identical for all six channels.
- R5: In a phase, a gate turns on only after its complementary gate has been off for exactly DEAD_CYC clock periods. This applies in both switching directions.
- R6: When both commands of a phase request on at the same time, both gates of that phase are off from the next edge on, until one request is withdrawn.
- R7: The shutdown input `stop_n` is active-low and filtered like the commands. Once its filtered value is 0, every gate is 0 from the next edge on. A stop pulse shorter than FILT_CYC samples has no effect.
- R8: While `kill` is 1, all six outputs are 0 in the same cycle. The gate state is also cleared at the next edge, so deadtime counting restarts from that edge.
- R9: The two gates of a phase are never 1 at the same time.
- R10: The three phases are independent. A command on one phase never changes the outputs of another phase.
- R11: With the default parameters, FILT_CYC is 325 ns divided by the clock period, rounded up. DEAD_CYC is 230 ns divided by the clock period, rounded up. At a 10 ns clock these are 33 and 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd_n | input | PHASES | High-side commands, active-low, one bit per phase |
| lo_cmd_n | input | PHASES | Low-side commands, active-low, one bit per phase |
| stop_n | input | 1 | Shutdown request, active-low, filtered |
| kill | input | 1 | Immediate disable from the protection logic, active-high |
| gate_hi | output | PHASES | High-side gate enables |
| gate_lo | output | PHASES | Low-side gate enables |

## Verification
A filter counter that holds a wrong value shows up at the ports as a gate edge that is one or more cycles early or late. A counter that failed to clear lets a short glitch through as a gate pulse, FILT_CYC+1 edges after the glitch. A deadtime counter with a wrong value changes the length of the both-off gap, and the bench sees this on the very edge where the incoming gate rises. A reset value that is wrong delays the first turn-on. A blocking condition that is missing gives an overlap, or an output that is not zero during a kill, in the same cycle. The bench model predicts every output on every clock, so any of these errors is reported in the cycle where it first appears.

// File: rtl/tph_pkg.sv
`timescale 1ns/1ps
package tph_pkg;

   // Cycles needed to cover a time given in ns, rounded up.
   function automatic int unsigned ns_to_cyc(input int unsigned ns_val,
                                             input int unsigned clk_ps);
      return (ns_val * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   // Index layout of the filtered command vector.
   typedef enum logic [1:0] {
      CH_HIGH = 2'd0,
      CH_LOW  = 2'd1,
      CH_STOP = 2'd2
   } chan_kind_e;

endpackage

// File: rtl/tph_glitch_filt.sv
`timescale 1ns/1ps
module tph_glitch_filt #(
   parameter int unsigned HOLD    = 4,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (HOLD <= 1) begin : g_direct
         // No filtering requested: one register keeps the latency uniform.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= RST_VAL;
            else        dout <= din;
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(HOLD);
         localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dout  <= RST_VAL;
               run_q <= '0;
            end else if (din == dout) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               dout  <= din;
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (din == dout) |=> (run_q == '0)); // R3
      end
   endgenerate

   AST_FILT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> (dout == $past(din))); // R3

endmodule

// File: rtl/tph_dead_leg.sv
`timescale 1ns/1ps
module tph_dead_leg #(
   parameter int unsigned DEAD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_hi,
   input  logic req_lo,
   input  logic blk,
   output logic on_hi,
   output logic on_lo
);

   localparam int unsigned CW = (DEAD < 2) ? 1 : $clog2(DEAD + 1);
   localparam logic [CW-1:0] SAT = CW'(DEAD);

   // Periods each side has been off, counting the current one, saturating at SAT.
   logic [CW-1:0] hi_off_q, lo_off_q;
   logic          go_hi, go_lo;
   logic          hi_ready, lo_ready;

   assign hi_ready = !on_lo && (lo_off_q == SAT);
   assign lo_ready = !on_hi && (hi_off_q == SAT);

   assign go_hi = req_hi && !req_lo && !blk && hi_ready;
   assign go_lo = req_lo && !req_hi && !blk && lo_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_hi    <= 1'b0;
         on_lo    <= 1'b0;
         hi_off_q <= SAT;
         lo_off_q <= SAT;
      end else begin
         on_hi <= go_hi;
         on_lo <= go_lo;
         if (on_hi)               hi_off_q <= CW'(1);
         else if (hi_off_q != SAT) hi_off_q <= hi_off_q + 1'b1;
         if (on_lo)               lo_off_q <= CW'(1);
         else if (lo_off_q != SAT) lo_off_q <= lo_off_q + 1'b1;
      end
   end

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(on_hi && on_lo)); // R9
   AST_HI_AFTER_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_hi) |-> $past(!on_lo)); // R5
   AST_LO_AFTER_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_lo) |-> $past(!on_hi)); // R5
   AST_HI_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_hi) |-> $past(req_hi)); // R2
   AST_LO_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_lo) |-> $past(req_lo)); // R2
   AST_BOTH_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hi && req_lo) |=> (!on_hi && !on_lo)); // R6
   AST_BLOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      blk |=> (!on_hi && !on_lo)); // R7

endmodule

// File: rtl/tph_gate_cond.sv
`timescale 1ns/1ps
module tph_gate_cond #(
   parameter int unsigned PHASES   = 3,
   parameter int unsigned CLK_PS   = 10000,
   parameter int unsigned FILT_NS  = 325,
   parameter int unsigned DEAD_NS  = 230,
   parameter int unsigned FILT_CYC = tph_pkg::ns_to_cyc(FILT_NS, CLK_PS),
   parameter int unsigned DEAD_CYC = tph_pkg::ns_to_cyc(DEAD_NS, CLK_PS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHASES-1:0] hi_cmd_n,
   input  logic [PHASES-1:0] lo_cmd_n,
   input  logic              stop_n,
   input  logic              kill,
   output logic [PHASES-1:0] gate_hi,
   output logic [PHASES-1:0] gate_lo
);

   import tph_pkg::*;

   localparam int unsigned NFILT  = 2 * PHASES + 1;
   localparam int unsigned STOP_I = NFILT - 1;

   initial begin : elab_chk
      assert (PHASES >= 1) else $error("PHASES must be at least 1");
      assert (DEAD_CYC >= 1) else $error("DEAD_CYC must be at least 1");
      assert (CLK_PS >= 1) else $error("CLK_PS must be nonzero");
   end

   logic [NFILT-1:0]  raw_n, clean_n;
   logic [PHASES-1:0] hq, lq;
   logic              blk;

   assign raw_n = {stop_n, lo_cmd_n, hi_cmd_n};

   // Identical filter on every command and on the stop input.
   generate
      for (genvar i = 0; i < NFILT; i++) begin : g_filt
         tph_glitch_filt #(.HOLD(FILT_CYC), .RST_VAL(1'b1)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_n[i]),
            .dout (clean_n[i])
         );
      end
   endgenerate

   assign blk = !clean_n[STOP_I] || kill;

   generate
      for (genvar p = 0; p < PHASES; p++) begin : g_leg
         tph_dead_leg #(.DEAD(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .req_hi(!clean_n[p]),
            .req_lo(!clean_n[PHASES + p]),
            .blk   (blk),
            .on_hi (hq[p]),
            .on_lo (lq[p])
         );
      end
   endgenerate

   assign gate_hi = hq & {PHASES{!kill}};
   assign gate_lo = lq & {PHASES{!kill}};

   AST_KILL_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      kill |-> ((gate_hi == '0) && (gate_lo == '0))); // R8
   AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> ((hq == '0) && (lq == '0))); // R8
   AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate_hi & gate_lo) == '0)); // R9

endmodule

// File: tb/tph_gate_cond_tb.sv
`timescale 1ns/1ps
module tph_gate_cond_tb_top;

   localparam int FILT_EXP = (325 * 1000 + 10000 - 1) / 10000; // R11: 33
   localparam int DEAD_EXP = (230 * 1000 + 10000 - 1) / 10000; // R11: 23

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hi_cmd_n = 3'b111;
   logic [2:0] lo_cmd_n = 3'b111;
   logic       stop_n = 1'b1;
   logic       kill = 1'b0;
   logic [2:0] gate_hi, gate_lo;

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag = "R1";
   bit    done = 1'b0;

   always #5 clk = ~clk;

   tph_gate_cond dut_i (
      .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
      .stop_n(stop_n), .kill(kill), .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   // ---------------- behavioural reference ----------------
   int run_len [7];
   bit last_v  [7];
   bit flt     [7];
   bit mh [3];
   bit ml [3];
   int hi_off_at [3];
   int lo_off_at [3];
   int cyc = 0;

   function automatic bit raw_in(int i);
      if (i < 3) return hi_cmd_n[i];
      if (i < 6) return lo_cmd_n[i-3];
      return stop_n;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 7; i++) begin run_len[i] = 0; last_v[i] = 1; flt[i] = 1; end
         for (int p = 0; p < 3; p++) begin
            mh[p] = 0; ml[p] = 0; hi_off_at[p] = -100000; lo_off_at[p] = -100000;
         end
         cyc = 0;
      end else begin
         bit stopped;
         stopped = (flt[6] == 0) || kill;
         for (int p = 0; p < 3; p++) begin
            bit wh, wl, nh, nl;
            wh = !flt[p];
            wl = !flt[3+p];
            nh = wh && !wl && !stopped && !ml[p] && (cyc - lo_off_at[p] >= DEAD_EXP);
            nl = wl && !wh && !stopped && !mh[p] && (cyc - hi_off_at[p] >= DEAD_EXP);
            if (mh[p]) hi_off_at[p] = cyc;
            if (ml[p]) lo_off_at[p] = cyc;
            mh[p] = nh;
            ml[p] = nl;
         end
         for (int i = 0; i < 7; i++) begin
            bit v;
            v = raw_in(i);
            if (v == last_v[i]) begin
               if (run_len[i] < 1000) run_len[i]++;
            end else run_len[i] = 1;
            last_v[i] = v;
            if (run_len[i] >= FILT_EXP && flt[i] != v) flt[i] = v;
         end
         cyc++;
      end
   end

   // Compare on every cycle, away from the active edge.
   always @(negedge clk) begin
      #2;
      if (!done) begin
         logic [2:0] eh, el;
         for (int p = 0; p < 3; p++) begin
            eh[p] = rst_n ? (mh[p] && !kill) : 1'b0;
            el[p] = rst_n ? (ml[p] && !kill) : 1'b0;
         end
         n_cmp++;
         if (gate_hi !== eh || gate_lo !== el) begin
            n_bad++;
            $display("FAIL %s cycle %0d: hi=%b lo=%b expected hi=%b lo=%b",
                     tag, cyc, gate_hi, gate_lo, eh, el);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #3;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin : seq
      int n;
      logic [15:0] lfsr;

      // R1: reset state
      tag = "R1";
      repeat (3) step();
      chk("R1 reset hi", gate_hi, 0);
      chk("R1 reset lo", gate_lo, 0);
      @(negedge clk); rst_n = 1'b1;
      step();
      chk("R1 after release", {gate_hi, gate_lo}, 0);

      // R2/R4/R11: latency of first turn-on, low side of phase 0
      tag = "R4";
      @(negedge clk); lo_cmd_n[0] = 1'b0;
      n = 0;
      do begin step(); n++; end while (!gate_lo[0] && n < 200);
      chk("R4 R11 R2 low latency", n, FILT_EXP + 1);

      // R4/R10: same latency on high side of phase 2, phase 0 unaffected
      tag = "R10";
      @(negedge clk); hi_cmd_n[2] = 1'b0;
      n = 0;
      do begin step(); n++; end while (!gate_hi[2] && n < 200);
      chk("R4 high latency", n, FILT_EXP + 1);
      chk("R10 phase0 held", gate_lo[0], 1);

      // R3: short glitch on phase 1 high is rejected
      tag = "R3";
      @(negedge clk); hi_cmd_n[1] = 1'b0;
      repeat (FILT_EXP - 1) @(negedge clk);
      hi_cmd_n[1] = 1'b1;
      repeat (FILT_EXP + 5) step();
      chk("R3 glitch rejected", gate_hi[1], 0);

      // R5: low to high on phase 0, both-off gap
      tag = "R5";
      @(negedge clk); lo_cmd_n[0] = 1'b1; hi_cmd_n[0] = 1'b0;
      n = 0;
      do begin step(); n++; end while (gate_lo[0] && n < 200);
      n = 0;
      while (!gate_hi[0] && !gate_lo[0] && n < 200) begin n++; step(); end
      chk("R5 gap lo->hi", n, DEAD_EXP);
      chk("R5 hi now on", gate_hi[0], 1);

      // R5: high to low on phase 0
      @(negedge clk); hi_cmd_n[0] = 1'b1; lo_cmd_n[0] = 1'b0;
      n = 0;
      do begin step(); n++; end while (gate_hi[0] && n < 200);
      n = 0;
      while (!gate_hi[0] && !gate_lo[0] && n < 200) begin n++; step(); end
      chk("R5 gap hi->lo", n, DEAD_EXP);
      chk("R5 lo now on", gate_lo[0], 1);

      // R6: both requests on phase 2
      tag = "R6";
      @(negedge clk); lo_cmd_n[2] = 1'b0;
      repeat (FILT_EXP + 3) step();
      chk("R6 both requested hi", gate_hi[2], 0);
      chk("R6 both requested lo", gate_lo[2], 0);
      @(negedge clk); lo_cmd_n[2] = 1'b1;
      repeat (FILT_EXP + DEAD_EXP + 3) step();
      chk("R6 released hi back", gate_hi[2], 1);

      // R7: short stop pulse ignored, long one stops all
      tag = "R7";
      @(negedge clk); stop_n = 1'b0;
      repeat (FILT_EXP - 1) @(negedge clk);
      stop_n = 1'b1;
      repeat (FILT_EXP + 3) step();
      chk("R7 short stop ignored", gate_lo[0], 1);
      @(negedge clk); stop_n = 1'b0;
      repeat (FILT_EXP + 3) step();
      chk("R7 stop all off", {gate_hi, gate_lo}, 0);
      @(negedge clk); stop_n = 1'b1;
      repeat (FILT_EXP + 3) step();
      chk("R7 recovered", gate_lo[0], 1);

      // R8: kill acts in the same cycle
      tag = "R8";
      @(negedge clk); kill = 1'b1;
      #1;
      chk("R8 kill same cycle", {gate_hi, gate_lo}, 0);
      step();
      @(negedge clk); kill = 1'b0;
      #3;
      chk("R8 state cleared", {gate_hi, gate_lo}, 0);
      repeat (3) step();
      chk("R8 resumes", gate_lo[0], 1);

      // R9/R10: pseudo-random stimulus across phases
      tag = "R10";
      lfsr = 16'hACE1;
      for (int k = 0; k < 6000; k++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         kill = (lfsr[15:10] == 6'd0);
         if (lfsr[4:0] == 5'd0) begin
            int idx;
            idx = int'(lfsr[10:8]) % 7;
            if (idx < 3) hi_cmd_n[idx] = ~hi_cmd_n[idx];
            else if (idx < 6) lo_cmd_n[idx-3] = ~lo_cmd_n[idx-3];
            else if (lfsr[7]) stop_n = ~stop_n;
         end
         #3;
         chk("R9 no overlap", int'(gate_hi & gate_lo), 0);
      end
      @(negedge clk); kill = 1'b0; stop_n = 1'b1;
      repeat (100) step();
      finish_run();
   end

endmodule